// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose IO data path. Each line can be an output or an input, and a register port gives software access to its data and direction. On a data access the offset carries the pin selection. Offset bits [9:2] form an eight-bit pin mask, so one read or one write touches any chosen subset of lines. Software never needs a read-modify-write sequence to change one pin without disturbing its neighbours.

Output lines take their level from the data register. Input lines pass through a two-flop synchronizer, and the result is written into the data register every cycle. A line set as input that has a pull-up drives its output value to 1. A line set as input with no pull-up floats, and its output value keeps the level it had before. The output-enable bits follow the direction register. The read port is combinational, so read data reflects the current address in the same cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: Any offset from 0x000 to 0x3FF selects the data register. Offset bits [9:2] form the pin mask, with bit 2 selecting pin 0.
- R2: A data read returns the data register ANDed with the pin mask. Pins outside the mask read as 0.
- R3: A data write changes only the data bits whose pin is set both in the mask and in the direction register. Bits of input pins are never changed by a write.
- R4: The direction register sits at offset 0x400 and can be read back there. A 1 makes the pin an output and a 0 makes it an input. Its reset value is 0, and a write there loads all eight bits.
- R5: For an input pin, the data bit takes the external pin level three clock edges after that level is applied: two synchronizer flops, then the data register.
- R6: For an output pin, the output value equals its data bit.
- R7: For an input pin, the output value is 1 when the PULL_UP parameter bit is set. Otherwise the output value holds its previous level.
- R8: The output-enable bits equal the direction register.
- R9: At any offset other than the data range and 0x400, a read returns 0 and a write changes nothing.
- R10: After reset, the data register is 0, every pin is an input, and the output values equal PULL_UP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write data |
| wen | input | 1 | Write enable for this cycle |
| rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The hardest case to reach is a floating input line that keeps an output level set earlier, while masked writes and sampled inputs change the bits around it. To reach it, the stimulus makes a line an output, drives it high or low, and then turns it back into an input that has no pull-up. The ports show only the held level, so the bench runs a reference model of the hold state. Random stimulus mixes direction changes with data offsets carrying arbitrary masks and with writes to unused offsets.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPINS = 8,
  parameter int ADDR_W = 12,
  parameter logic [NPINS-1:0] PULL_UP = NPINS'('h0F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic              wen,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int MSB = NPINS + 2;
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << MSB;

  logic [NPINS-1:0] sync1, sync2, data_q, dir_q, hold_q;
  logic [NPINS-1:0] amask, wmask;
  logic hit_data, hit_dir;

  assign hit_data = (addr[ADDR_W-1:MSB] == '0);
  assign hit_dir  = (addr == DIR_OFS);
  assign amask    = addr[MSB-1:2];
  assign wmask    = (wen && hit_data) ? amask : '0;

  assign rdata = hit_data ? (data_q & amask) :
                 hit_dir  ? dir_q : '0;

  assign pin_out = (dir_q & data_q) | (~dir_q & PULL_UP) |
                   (~dir_q & ~PULL_UP & hold_q);
  assign pin_oe  = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      hold_q <= PULL_UP;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      data_q <= (dir_q & ((wmask & wdata) | (~wmask & data_q))) | (~dir_q & sync2);
      if (wen && hit_dir) dir_q <= wdata;
      hold_q <= pin_out;
    end
  end
endmodule

module gpio_mask_port_chk #(
  parameter int NPINS = 8,
  parameter int ADDR_W = 12,
  parameter logic [NPINS-1:0] PULL_UP = NPINS'('h0F)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wdata,
  input logic              wen,
  input logic [NPINS-1:0]  rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  data_q,
  input logic [NPINS-1:0]  sync2
);
  localparam int MSB = NPINS + 2;
  logic is_data, is_dir;
  logic [NPINS-1:0] wm;
  assign is_data = (addr[ADDR_W-1:MSB] == '0);
  assign is_dir  = (addr == (ADDR_W'(1) << MSB));
  assign wm      = (wen && is_data) ? addr[MSB-1:2] : '0;

  a_r2_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_data |-> ((rdata & ~addr[MSB-1:2]) == '0));
  a_r3_outside_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(pin_oe) & ~$past(wm)) == '0));
  a_r4_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && is_dir) |=> (pin_oe == $past(wdata)));
  a_r5_input_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(sync2)) & ~$past(pin_oe)) == '0));
  a_r6_output_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ data_q) & pin_oe) == '0);
  a_r7_pullup_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_oe & PULL_UP & ~pin_out) == '0));
  a_r7_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~pin_oe & ~$past(pin_oe) & ~PULL_UP) == '0));
  a_r9_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_data && !is_dir) |-> (rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .PULL_UP(PULL_UP)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen), .rdata(rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .data_q(data_q), .sync2(sync2)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
  localparam int PERIOD = 10;
  localparam logic [7:0] PU = 8'h0F;

  logic clk = 0, rst_n = 0, wen = 0;
  logic [11:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_mask_port dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  // behavioural reference model
  logic [7:0] m_s1, m_s2, m_data, m_dir, m_hold;

  function automatic logic [7:0] exp_out();
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      if (m_dir[i]) o[i] = m_data[i];
      else if (PU[i]) o[i] = 1'b1;
      else o[i] = m_hold[i];
    return o;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [11:0] a);
    if (a < 12'h400) return m_data & a[9:2];
    if (a == 12'h400) return m_dir;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_data = 0; m_dir = 0; m_hold = PU;
    end else begin
      logic [7:0] o, nd;
      o = exp_out();
      nd = m_data;
      for (int i = 0; i < 8; i++) begin
        if (!m_dir[i]) nd[i] = m_s2[i];
        else if (wen && addr < 12'h400 && addr[2+i]) nd[i] = wdata[i];
      end
      if (wen && addr == 12'h400) m_dir = wdata;
      m_data = nd;
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_hold = o;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(addr < 12'h400 ? "R2 model read" : addr == 12'h400 ? "R4 model read" : "R9 model read",
        rdata, exp_rd(addr));
    chk("R6 R7 model pin_out", pin_out, exp_out());
    chk("R8 model pin_oe", pin_oe, m_dir);
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wen = 1;
    @(posedge clk); #1; wen = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input logic [7:0] exp);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 reset pin_out", pin_out, PU);
    chk("R10 reset pin_oe", pin_oe, 8'h00);
    rd(12'h3FC, "R10 reset data", 8'h00);
    rd(12'h400, "R10 reset dir", 8'h00);

    wr(12'h400, 8'hFF);
    rd(12'h400, "R4 dir readback", 8'hFF);
    chk("R8 oe after dir write", pin_oe, 8'hFF);
    wr(12'h3FC, 8'hAA);
    chk("R1 R6 full-mask write drives pins", pin_out, 8'hAA);
    wr(12'h03C, 8'h55);
    rd(12'h3FC, "R3 partial mask write", 8'hA5);
    rd(12'h03C, "R2 masked read", 8'h05);
    rd(12'h004, "R1 single pin mask", 8'h01);

    wr(12'h404, 8'h00);
    rd(12'h404, "R9 unused offset read", 8'h00);
    rd(12'h400, "R9 dir untouched", 8'hFF);
    chk("R9 pins untouched", pin_out, 8'hA5);

    pin_in = 8'h30;
    wr(12'h400, 8'h0F);
    chk("R7 floating inputs hold level", pin_out, 8'hA5);
    repeat (4) @(posedge clk);
    #1;
    rd(12'h3FC, "R5 inputs sampled", 8'h35);
    wr(12'h3FC, 8'hFF);
    rd(12'h3FC, "R3 input bits not written", 8'h3F);

    wr(12'h400, 8'hF0);
    chk("R7 pulled-up inputs high", pin_out, 8'h3F);

    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      case ($urandom_range(0, 7))
        0, 1, 2, 3, 4: begin addr = {2'b00, 10'($urandom)}; wen = $urandom_range(0, 1) == 1; end
        5: begin addr = 12'h400; wen = $urandom_range(0, 3) == 0; end
        default: begin addr = 12'($urandom) | 12'h404; wen = $urandom_range(0, 1) == 1; end
      endcase
      wdata = 8'($urandom);
    end
    @(posedge clk); #1 wen = 0;
    @(negedge clk);
    finish_run();
  end
endmodule